// File: doc/BRIEF.md
# Bypassable Clock-Domain Channel Slice

This block is one valid/ready channel stage between a source-side port and a destination-side port. In its normal, decoupled mode every beat goes through a small dual-clock FIFO, so the two sides may run from unrelated clocks. Each beat then pays a few cycles of synchronisation on each side. In its direct mode a multiplexer connects the source handshake and payload straight to the destination, with no added cycle. This mode is meant for the case where both sides run on one clock and full speed matters.

A request/acknowledge pair moves the stage between the two modes. After the request rises, the stage lets any burst that has already started finish. It then closes its input and waits for the FIFO to drain. Only after that does it switch to the direct path and raise the acknowledge. When the request falls, the stage goes back to the FIFO path and lowers the acknowledge a fixed single cycle later. Several stages can therefore share one request line and AND their acknowledges. A chain-enable input holds off the close step, so the stages can also be switched one after another in a daisy chain. The request, acknowledge and chain-enable all belong to the source clock domain.

Top module: `xdom_bypass_slice`

## Requirements
- R1: After reset the stage is in decoupled mode: `mode_ack` is 0, `dst_valid` is 0 and `src_ready` is 1.
- R2: In decoupled mode, beats reach the destination in order and unchanged (payload and `last`), also with unrelated clocks. With the destination stalled, the stage accepts exactly `FIFO_DEPTH` beats and then holds `src_ready` at 0.
- R3: In decoupled mode with both clocks from one source, a beat accepted on source edge E is first shown on `dst_valid` after edge E+2. It is not shown after edge E+1.
- R4: Take the case where `mode_req` is 1, `chain_en` is 1 and no burst is open. From the first edge that samples the request, `src_ready` stays 0 until the acknowledge. `mode_ack` rises only when every buffered beat has been delivered. With an already empty FIFO it rises on the third edge that samples `mode_req` high.
- R5: A burst is open from an accepted beat with `src_last`=0 until an accepted beat with `src_last`=1. If a request arrives while a burst is open, `src_ready` keeps following FIFO space until that final beat. From the next cycle on, the input is closed.
- R6: While `chain_en` is 0, a pending request neither closes the input nor raises `mode_ack`, and beats are still accepted. When `chain_en` rises with no burst open, `src_ready` drops to 0.
- R7: While `mode_ack` is 1, the destination sees the source combinationally in the same cycle: `dst_valid`=`src_valid`, `dst_data`=`src_data`, `dst_last`=`src_last`, and `src_ready`=`dst_ready`.
- R8: After `mode_req` falls, `mode_ack` is 0 following the next source edge, and the source is served by the FIFO path again.
- R9: Across any sequence of mode switches, no beat is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-side clock; it also clocks the mode controller |
| src_rst_n | input | 1 | Active-low reset, source domain |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Stage can take a source beat |
| src_data | input | DATA_W | Source payload |
| src_last | input | 1 | Marks the final beat of a burst |
| dst_clk | input | 1 | Destination-side clock |
| dst_rst_n | input | 1 | Active-low reset, destination domain |
| dst_valid | output | 1 | Destination beat valid |
| dst_ready | input | 1 | Destination can take a beat |
| dst_data | output | DATA_W | Destination payload |
| dst_last | output | 1 | Final-beat marker toward the destination |
| mode_req | input | 1 | Request for direct mode (level) |
| chain_en | input | 1 | Permits the close step (previous stage already direct) |
| mode_ack | output | 1 | Stage is in direct mode |

## Verification
The properties rely on a few facts about the inputs. Both clocks are one and the same clock whenever the request is high or the acknowledge is set. `chain_en` does not fall once the input has closed for a switch. The source holds `src_valid` and its payload until the beat is taken. The bench ties the destination clock to the source clock before it raises any request, and it releases that tie only after the acknowledge is low and the FIFO is idle. Every source beat is held until a sampled `src_ready` shows it was taken. The destination ready signal changes only just after a destination edge.

// File: rtl/xdom_pkg.sv
`timescale 1ns/1ps
package xdom_pkg;
  typedef enum logic [1:0] {
    MODE_DECOUPLED = 2'd0,
    MODE_CLOSING   = 2'd1,
    MODE_DRAINING  = 2'd2,
    MODE_DIRECT    = 2'd3
  } mode_e;
endpackage

// File: rtl/xdom_sync2.sv
`timescale 1ns/1ps
module xdom_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xdom_afifo.sv
`timescale 1ns/1ps
module xdom_afifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full_w,
  output logic          empty_w,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty_r
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic is_full(input logic [PW-1:0] wg, input logic [PW-1:0] rg);
    return wg == {~rg[PW-1:PW-2], rg[PW-3:0]};
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_at_w, wgray_at_r;

  xdom_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w));
  xdom_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r));

  assign full_w  = is_full(wgray, rgray_at_w);
  assign empty_w = (wgray == rgray_at_w);
  assign empty_r = (rgray == wgray_at_r);
  assign rdata   = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (push && !full_w) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push && !full_w) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop && !empty_r) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end
endmodule

// File: rtl/xdom_mode_ctl.sv
`timescale 1ns/1ps
module xdom_mode_ctl
  import xdom_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  chain_en,
  input  logic  accept,
  input  logic  last,
  input  logic  drained,
  output mode_e state,
  output logic  gate_open,
  output logic  direct_sel,
  output logic  in_burst
);
  mode_e nxt;

  always_comb begin
    nxt       = state;
    gate_open = 1'b0;
    unique case (state)
      MODE_DECOUPLED: begin
        gate_open = 1'b1;
        if (req) nxt = MODE_CLOSING;
      end
      MODE_CLOSING: begin
        gate_open = in_burst || !chain_en;
        if (!req) nxt = MODE_DECOUPLED;
        else if (chain_en && !in_burst) nxt = MODE_DRAINING;
      end
      MODE_DRAINING: begin
        if (!req) nxt = MODE_DECOUPLED;
        else if (drained) nxt = MODE_DIRECT;
      end
      MODE_DIRECT: begin
        if (!req) nxt = MODE_DECOUPLED;
      end
      default: nxt = MODE_DECOUPLED;
    endcase
  end

  assign direct_sel = (state == MODE_DIRECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MODE_DECOUPLED;
      in_burst <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) in_burst <= !last;
    end
  end
endmodule

// File: rtl/xdom_bypass_slice.sv
`timescale 1ns/1ps
module xdom_bypass_slice
  import xdom_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_last,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_last,
  input  logic              mode_req,
  input  logic              chain_en,
  output logic              mode_ack
);
  localparam int BEAT_W = DATA_W + 1;

  mode_e             state;
  logic              gate_open, direct_sel, in_burst;
  logic              wr_full, wr_empty, rd_empty;
  logic              fifo_push, fifo_pop, src_accept;
  logic [BEAT_W-1:0] fifo_out;

  assign src_accept = src_valid && src_ready;
  assign fifo_push  = src_valid && gate_open && !wr_full && !direct_sel;
  assign fifo_pop   = dst_ready && !rd_empty && !direct_sel;

  xdom_mode_ctl u_ctl (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .req       (mode_req),
    .chain_en  (chain_en),
    .accept    (src_accept),
    .last      (src_last),
    .drained   (wr_empty),
    .state     (state),
    .gate_open (gate_open),
    .direct_sel(direct_sel),
    .in_burst  (in_burst)
  );

  xdom_afifo #(.DW(BEAT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk   (src_clk),
    .wrst_n (src_rst_n),
    .push   (fifo_push),
    .wdata  ({src_last, src_data}),
    .full_w (wr_full),
    .empty_w(wr_empty),
    .rclk   (dst_clk),
    .rrst_n (dst_rst_n),
    .pop    (fifo_pop),
    .rdata  (fifo_out),
    .empty_r(rd_empty)
  );

  always_comb begin
    if (direct_sel) begin
      src_ready = dst_ready;
      dst_valid = src_valid;
      dst_data  = src_data;
      dst_last  = src_last;
    end else begin
      src_ready = gate_open && !wr_full;
      dst_valid = !rd_empty;
      dst_data  = fifo_out[DATA_W-1:0];
      dst_last  = fifo_out[DATA_W];
    end
  end

  assign mode_ack = direct_sel;
endmodule

// File: rtl/xdom_bypass_slice_chk.sv
`timescale 1ns/1ps
module xdom_bypass_slice_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic [DATA_W-1:0] src_data,
  input logic              src_last,
  input logic              dst_valid,
  input logic              dst_ready,
  input logic [DATA_W-1:0] dst_data,
  input logic              dst_last,
  input logic              mode_req,
  input logic              chain_en,
  input logic              mode_ack,
  input logic              wr_full,
  input logic              wr_empty,
  input logic              in_burst
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !mode_ack) |-> !src_ready);

  p_closed_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && $past(mode_req) && chain_en && !in_burst && !mode_ack) |-> !src_ready);

  p_ack_after_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ack) |-> $past(wr_empty));

  p_burst_kept_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && in_burst && !mode_ack) |-> (src_ready == !wr_full));

  p_direct_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ack |-> (dst_valid == src_valid && dst_data == src_data &&
                  dst_last == src_last && src_ready == dst_ready));

  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req |=> !mode_ack);
endmodule

bind xdom_bypass_slice xdom_bypass_slice_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (src_clk),
  .rst_n    (src_rst_n),
  .src_valid(src_valid),
  .src_ready(src_ready),
  .src_data (src_data),
  .src_last (src_last),
  .dst_valid(dst_valid),
  .dst_ready(dst_ready),
  .dst_data (dst_data),
  .dst_last (dst_last),
  .mode_req (mode_req),
  .chain_en (chain_en),
  .mode_ack (mode_ack),
  .wr_full  (wr_full),
  .wr_empty (wr_empty),
  .in_burst (in_burst)
);

// File: tb/xdom_bypass_slice_tb.sv
`timescale 1ns/1ps
module xdom_bypass_slice_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 8;

  logic src_clk = 1'b0, dfree = 1'b0, tie = 1'b1;
  logic dst_clk;
  always #2.5 src_clk = ~src_clk;
  always #3.5 dfree   = ~dfree;
  assign dst_clk = tie ? src_clk : dfree;

  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic src_valid = 1'b0, src_last = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, dst_valid, dst_last, mode_ack;
  logic [DW-1:0] dst_data;
  logic dst_ready = 1'b0;
  logic mode_req = 1'b0, chain_en = 1'b1;

  xdom_bypass_slice #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_data(dst_data), .dst_last(dst_last),
    .mode_req(mode_req), .chain_en(chain_en), .mode_ack(mode_ack)
  );

  int checks = 0, fails = 0;
  int next_id = 0, exp_id = 0, dcnt = 0;
  bit exp_last [256];
  logic sink_want = 1'b1, pat_en = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // destination ready changes just after each destination edge
  always @(posedge dst_clk) begin
    #0.5;
    dcnt++;
    dst_ready = sink_want && !(pat_en && (dcnt % 3 == 0));
  end

  // scoreboard: beats are taken at the edge following this sample
  always @(negedge dst_clk) begin
    if (dst_valid && dst_ready) begin
      check(dst_data == exp_id[DW-1:0], "R9 beat order", int'(dst_data), exp_id);
      check(dst_last == exp_last[exp_id % 256], "R2 last flag", int'(dst_last),
            int'(exp_last[exp_id % 256]));
      exp_id++;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge src_clk);
      #1;
    end
  endtask

  task automatic push(input bit lst);
    bit ok;
    src_valid = 1'b1;
    src_data  = next_id[DW-1:0];
    src_last  = lst;
    exp_last[next_id % 256] = lst;
    do begin
      @(negedge src_clk);
      ok = src_ready;
      @(posedge src_clk);
      #1;
    end while (!ok);
    src_valid = 1'b0;
    next_id++;
  endtask

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 400 && exp_id != next_id; i++) tick(1);
    check(exp_id == next_id, tag, exp_id, next_id);
  endtask

  task automatic wait_ack(input string tag);
    for (int i = 0; i < 60 && !mode_ack; i++) tick(1);
    check(mode_ack == 1'b1, tag, int'(mode_ack), 1);
  endtask

  task automatic leave_direct();
    mode_req = 1'b0;
    tick(1);
    check(mode_ack == 1'b0, "R8 ack low one edge after request falls", int'(mode_ack), 0);
    check(src_ready == 1'b1, "R8 FIFO path serves source", int'(src_ready), 1);
  endtask

  task automatic t_reset();
    tick(4);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    tick(2);
    check(mode_ack == 1'b0, "R1 ack after reset", int'(mode_ack), 0);
    check(dst_valid == 1'b0, "R1 dst_valid after reset", int'(dst_valid), 0);
    check(src_ready == 1'b1, "R1 src_ready after reset", int'(src_ready), 1);
  endtask

  task automatic t_latency();
    push(1'b1);                 // accepted on edge E, now at E + 1ns
    tick(1);
    check(dst_valid == 1'b0, "R3 not visible after E+1", int'(dst_valid), 0);
    tick(1);
    check(dst_valid == 1'b1, "R3 visible after E+2", int'(dst_valid), 1);
    wait_drain("R3 beat delivered");
  endtask

  task automatic t_unrelated_stream();
    tie = 1'b0;
    tick(4);
    pat_en = 1'b1;
    for (int i = 0; i < 24; i++) push((i % 4) == 3);
    wait_drain("R2 stream across unrelated clocks");
    pat_en = 1'b0;
  endtask

  task automatic t_full();
    sink_want = 1'b0;
    tick(4);
    for (int i = 0; i < DEPTH; i++) push(1'b1);
    tick(1);
    check(src_ready == 1'b0, "R2 ready low when FIFO holds DEPTH beats", int'(src_ready), 0);
    check(exp_id + DEPTH == next_id, "R2 nothing delivered while stalled", exp_id + DEPTH, next_id);
    sink_want = 1'b1;
    wait_drain("R2 full FIFO drains");
  endtask

  task automatic t_clean_switch();
    tie = 1'b1;
    tick(4);
    mode_req = 1'b1;
    tick(1);
    check(mode_ack == 1'b0, "R4 ack low after first edge", int'(mode_ack), 0);
    check(src_ready == 1'b0, "R4 input closed after first edge", int'(src_ready), 0);
    tick(1);
    check(mode_ack == 1'b0, "R4 ack low after second edge", int'(mode_ack), 0);
    tick(1);
    check(mode_ack == 1'b1, "R4 ack on third edge", int'(mode_ack), 1);
    // direct path: same-cycle wiring
    sink_want = 1'b0;
    tick(2);
    src_valid = 1'b1;
    src_data  = 16'hA5C3;
    src_last  = 1'b1;
    #0.2;
    check(dst_valid == 1'b1, "R7 valid wired", int'(dst_valid), 1);
    check(dst_data == 16'hA5C3, "R7 data wired", int'(dst_data), 16'hA5C3);
    check(dst_last == 1'b1, "R7 last wired", int'(dst_last), 1);
    check(src_ready == 1'b0, "R7 ready wired low", int'(src_ready), 0);
    src_valid = 1'b0;
    sink_want = 1'b1;
    tick(1);
    check(src_ready == 1'b1, "R7 ready wired high", int'(src_ready), 1);
    pat_en = 1'b1;
    for (int i = 0; i < 6; i++) push(i == 5);
    wait_drain("R9 beats in direct mode");
    pat_en = 1'b0;
    leave_direct();
  endtask

  task automatic t_drain_wait();
    sink_want = 1'b0;
    tick(3);
    for (int i = 0; i < 3; i++) push(1'b1);
    mode_req = 1'b1;
    tick(6);
    check(mode_ack == 1'b0, "R4 ack held while FIFO not empty", int'(mode_ack), 0);
    check(src_ready == 1'b0, "R4 input closed while draining", int'(src_ready), 0);
    sink_want = 1'b1;
    wait_ack("R4 ack after drain");
    check(exp_id == next_id, "R4 all beats out at ack", exp_id, next_id);
    leave_direct();
  endtask

  task automatic t_burst();
    push(1'b0);
    mode_req = 1'b1;
    tick(1);
    check(src_ready == 1'b1, "R5 input open during burst", int'(src_ready), 1);
    push(1'b0);
    push(1'b1);
    check(src_ready == 1'b0, "R5 input closed after final beat", int'(src_ready), 0);
    check(mode_ack == 1'b0, "R5 no ack yet", int'(mode_ack), 0);
    wait_ack("R5 ack after burst");
    check(exp_id == next_id, "R5 burst delivered whole", exp_id, next_id);
    leave_direct();
  endtask

  task automatic t_chain();
    chain_en = 1'b0;
    mode_req = 1'b1;
    tick(5);
    check(mode_ack == 1'b0, "R6 no ack without chain enable", int'(mode_ack), 0);
    check(src_ready == 1'b1, "R6 input stays open", int'(src_ready), 1);
    push(1'b1);
    wait_drain("R6 beat accepted while held");
    chain_en = 1'b1;
    #0.2;
    check(src_ready == 1'b0, "R6 input closes with chain enable", int'(src_ready), 0);
    wait_ack("R6 ack after chain enable");
    leave_direct();
  endtask

  task automatic t_final_stream();
    tick(3);
    tie = 1'b0;
    tick(4);
    pat_en = 1'b1;
    for (int i = 0; i < 10; i++) push(i % 2 == 1);
    wait_drain("R9 stream after switches");
    pat_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge src_clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_latency();
    t_unrelated_stream();
    t_full();
    t_clean_switch();
    t_drain_wait();
    t_burst();
    t_chain();
    t_final_stream();
    summary();
  end
endmodule